// File: doc/BRIEF.md
# Per-Processor Pending Interrupt Arbiter

This block sits between the interrupt bookkeeping of a multi-processor interrupt controller and the request lines into each processor. Every cycle it looks at a set of interrupt sources. Each source has an enable flag, a pending flag, an 8-bit urgency value and a mask of the processors it may be sent to. For each processor, the block finds the most urgent source that is eligible for that processor. It then decides whether that source is reported to the processor and whether the processor's request line is raised.

There are two thresholds per processor. The first is a programmable priority floor. A winner is reported only when its urgency value is below this floor. The second is the urgency of the interrupt the processor is already servicing. The request line rises only when the reported winner is more urgent than that. A processor with nothing in service presents a running value of 256, which any reported winner beats.

Register access, acknowledgement and the trigger mode of each source are handled by neighbouring blocks. They feed this block with plain vectors.

Top module: `irq_prio_select`

## Requirements
- R1: Source j is a candidate for processor c only when `srcEnable[j]`, `srcPending[j]` and `srcTarget[j*NUM_CPU+c]` are all 1. A source missing any of the three is never reported to that processor.
- R2: Among the candidates of a processor, the one with the numerically smallest urgency value wins. The urgency of source j is `srcPrio[j*8 +: 8]`.
- R3: When several candidates share the smallest urgency value, the one with the lowest source number wins.
- R4: While `distEnable` is 0, or while `cpuEnable[c]` is 0, processor c sees ID 1023 and a low request line.
- R5: A processor with no candidate sees ID 1023, the no-interrupt code, and a low request line. Any ID other than 1023 is below NUM_SRC.
- R6: The winner's number appears on `pendId[c*10 +: 10]` only when its urgency is strictly less than the floor `prioMask[c*8 +: 8]`. Otherwise the ID is 1023 and the request line is low, so a floor of 0 blocks everything.
- R7: `irqReq[c]` is 1 only when a winner is reported and its urgency is strictly less than `runPrio[c*9 +: 9]`. A running value of 256 (nothing in service) lets any reported winner raise the line, and a running value of 0 blocks it.
- R8: Both outputs are registered. They reflect the inputs present at the previous rising clock edge, and they do not change between edges. In reset, every ID is 1023 and every request line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| distEnable | input | 1 | Global forwarding enable |
| cpuEnable | input | NUM_CPU | Per-processor interface enable |
| srcEnable | input | NUM_SRC | Per-source enable |
| srcPending | input | NUM_SRC | Per-source pending flag |
| srcPrio | input | NUM_SRC*8 | Urgency of each source; a lower value is more urgent |
| srcTarget | input | NUM_SRC*NUM_CPU | Processor mask per source; bit j*NUM_CPU+c selects processor c |
| prioMask | input | NUM_CPU*8 | Per-processor priority floor |
| runPrio | input | NUM_CPU*9 | Urgency currently in service per processor; 256 means idle |
| pendId | output | NUM_CPU*10 | Reported source number per processor, 1023 if none |
| irqReq | output | NUM_CPU | Interrupt request line per processor |

## Verification
The assertions assume that the running urgency on each processor never exceeds 256 and that every input is a known value at each rising edge. Under these assumptions an ID other than 1023 always names a real source, and a request line never rises without a reported ID. The stimulus keeps to these assumptions. It draws running values only from 0 to 256 and holds all inputs fully driven from reset onward. It also crowds urgency values into a narrow range so that ties occur often.

// File: rtl/sel_pkg.sv
package sel_pkg;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] NO_IRQ_ID = 10'd1023;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;

  typedef struct packed {
    logic report;
    logic raise;
  } strobe_t;

  // Right operand wins only when strictly more urgent: ties keep the left (lower ID).
  function automatic cand_t pickBetter(cand_t lhs, cand_t rhs);
    if (rhs.valid && (!lhs.valid || (rhs.prio < lhs.prio))) return rhs;
    return lhs;
  endfunction
endpackage

// File: rtl/sel_datapath.sv
module sel_datapath
  import sel_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SRC = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            srcEnable,
  input  logic [NUM_SRC-1:0]            srcPending,
  input  logic [NUM_SRC*PRIO_W-1:0]     srcPrio,
  input  logic [NUM_SRC*NUM_CPU-1:0]    srcTarget,
  input  strobe_t [NUM_CPU-1:0]         strobes,
  output cand_t [NUM_CPU-1:0]           winner,
  output logic [NUM_CPU*ID_W-1:0]       pendId,
  output logic [NUM_CPU-1:0]            irqReq
);
  localparam int LEAVES = (NUM_SRC > 1) ? (1 << $clog2(NUM_SRC)) : 1;
  localparam int SRC_IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] eligible;
    cand_t              node [1:2*LEAVES-1];

    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < NUM_SRC) begin : g_real
        assign eligible[j] = srcEnable[j] & srcPending[j] & srcTarget[j*NUM_CPU+c];
        assign node[LEAVES+j] = '{valid: eligible[j],
                                  prio:  srcPrio[j*PRIO_W +: PRIO_W],
                                  id:    ID_W'(j)};
      end else begin : g_pad
        assign node[LEAVES+j] = '0;
      end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
      assign node[k] = pickBetter(node[2*k], node[2*k+1]);
    end

    assign winner[c] = node[1];

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      node[1].valid |-> eligible[node[1].id[SRC_IW-1:0]]); // R1
    AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      node[1].valid |-> (node[1].id < ID_W'(NUM_SRC))); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendId <= {NUM_CPU{NO_IRQ_ID}};
      irqReq <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        pendId[c*ID_W +: ID_W] <= strobes[c].report ? winner[c].id : NO_IRQ_ID;
        irqReq[c]              <= strobes[c].raise;
      end
    end
  end
endmodule

// File: rtl/sel_control.sv
module sel_control
  import sel_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic                      distEnable,
  input  logic [NUM_CPU-1:0]        cpuEnable,
  input  logic [NUM_CPU*PRIO_W-1:0] prioMask,
  input  logic [NUM_CPU*RUN_W-1:0]  runPrio,
  input  cand_t [NUM_CPU-1:0]       winner,
  output strobe_t [NUM_CPU-1:0]     strobes
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic gateOpen;
    logic belowFloor;
    logic beatsRunning;

    assign gateOpen     = distEnable & cpuEnable[c];
    assign belowFloor   = winner[c].prio < prioMask[c*PRIO_W +: PRIO_W];
    assign beatsRunning = {1'b0, winner[c].prio} < runPrio[c*RUN_W +: RUN_W];

    assign strobes[c].report = gateOpen & winner[c].valid & belowFloor;
    assign strobes[c].raise  = gateOpen & winner[c].valid & belowFloor & beatsRunning;
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import sel_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SRC = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       distEnable,
  input  logic [NUM_CPU-1:0]         cpuEnable,
  input  logic [NUM_SRC-1:0]         srcEnable,
  input  logic [NUM_SRC-1:0]         srcPending,
  input  logic [NUM_SRC*8-1:0]       srcPrio,
  input  logic [NUM_SRC*NUM_CPU-1:0] srcTarget,
  input  logic [NUM_CPU*8-1:0]       prioMask,
  input  logic [NUM_CPU*9-1:0]       runPrio,
  output logic [NUM_CPU*10-1:0]      pendId,
  output logic [NUM_CPU-1:0]         irqReq
);
  cand_t   [NUM_CPU-1:0] winner;
  strobe_t [NUM_CPU-1:0] strobes;

  sel_datapath #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .srcEnable  (srcEnable),
    .srcPending (srcPending),
    .srcPrio    (srcPrio),
    .srcTarget  (srcTarget),
    .strobes    (strobes),
    .winner     (winner),
    .pendId     (pendId),
    .irqReq     (irqReq)
  );

  sel_control #(.NUM_CPU(NUM_CPU)) i_control (
    .distEnable (distEnable),
    .cpuEnable  (cpuEnable),
    .prioMask   (prioMask),
    .runPrio    (runPrio),
    .winner     (winner),
    .strobes    (strobes)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!distEnable || !cpuEnable[c]) |=> (!irqReq[c] && pendId[c*10 +: 10] == NO_IRQ_ID)); // R4
    AST_REQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irqReq[c] |-> (pendId[c*10 +: 10] != NO_IRQ_ID)); // R7
    AST_RUN_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (runPrio[c*9 +: 9] == 9'd0) |=> !irqReq[c]); // R7
    AST_FLOOR_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (prioMask[c*8 +: 8] == 8'd0) |=> (pendId[c*10 +: 10] == NO_IRQ_ID)); // R6
    AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pendId[c*10 +: 10] != NO_IRQ_ID) |-> (pendId[c*10 +: 10] < 10'(NUM_SRC))); // R5
  end
endmodule

// File: tb/test_irq_prio_select.sv
module test_irq_prio_select;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic distEnable;
  logic [NC-1:0] cpuEnable;
  logic [NS-1:0] srcEnable, srcPending;
  logic [NS*8-1:0] srcPrio;
  logic [NS*NC-1:0] srcTarget;
  logic [NC*8-1:0] prioMask;
  logic [NC*9-1:0] runPrio;
  logic [NC*10-1:0] pendId;
  logic [NC-1:0] irqReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int expId [NC];
  bit expIrq [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_select #(.NUM_CPU(NC), .NUM_SRC(NS)) i_irq_prio_select (
    .clk(clk), .rst_n(rst_n), .distEnable(distEnable), .cpuEnable(cpuEnable),
    .srcEnable(srcEnable), .srcPending(srcPending), .srcPrio(srcPrio),
    .srcTarget(srcTarget), .prioMask(prioMask), .runPrio(runPrio),
    .pendId(pendId), .irqReq(irqReq)
  );

  // Behavioural reference: plain scan with integers.
  function automatic void model();
    for (int c = 0; c < NC; c++) begin
      int best = 256;
      int bestId = 1023;
      expId[c] = 1023;
      expIrq[c] = 0;
      if (distEnable && cpuEnable[c]) begin
        for (int j = 0; j < NS; j++) begin
          if (srcEnable[j] && srcPending[j] && srcTarget[j*NC+c] && int'(srcPrio[j*8 +: 8]) < best) begin
            best = int'(srcPrio[j*8 +: 8]);
            bestId = j;
          end
        end
        if (best < int'(prioMask[c*8 +: 8])) begin
          expId[c] = bestId;
          expIrq[c] = best < int'(runPrio[c*9 +: 9]);
        end
      end
    end
  endfunction

  task automatic compareAll(string tag);
    for (int c = 0; c < NC; c++) begin
      total++;
      if (int'(pendId[c*10 +: 10]) != expId[c]) begin
        bad++;
        $display("FAIL %s cpu%0d pendId act=%0d exp=%0d", tag, c, pendId[c*10 +: 10], expId[c]);
      end
      total++;
      if (irqReq[c] != expIrq[c]) begin
        bad++;
        $display("FAIL %s cpu%0d irqReq act=%0b exp=%0b", tag, c, irqReq[c], expIrq[c]);
      end
    end
  endtask

  // Inputs are set at a falling edge; the next falling edge sees the registered result.
  task automatic step(string tag);
    model();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic setPrio(int j, int v);
    srcPrio[j*8 +: 8] = 8'(v);
  endtask

  initial begin
    distEnable = 1; cpuEnable = '1; srcEnable = '1; srcPending = '0;
    srcTarget = '1; prioMask = '1; runPrio = {NC{9'd256}};
    for (int j = 0; j < NS; j++) setPrio(j, 8'h80);
    srcPending[1] = 1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin expId[c] = 1023; expIrq[c] = 0; end
    compareAll("R8 reset");
    rst_n = 1;
    srcPending = '0;
    step("R5 none");
    srcPending[5] = 1; setPrio(5, 8'h40);
    srcPending[9] = 1; setPrio(9, 8'h20);
    step("R2 lowest value");
    srcPending[3] = 1; setPrio(3, 8'h10);
    srcPending[7] = 1; setPrio(7, 8'h10);
    step("R3 tie");
    srcTarget[3*NC+2] = 0;
    step("R1 target");
    srcEnable[7] = 0;
    step("R1 enable");
    srcEnable[7] = 1;
    prioMask[0 +: 8] = 8'h10;
    step("R6 floor equal");
    prioMask[0 +: 8] = 8'h11;
    prioMask[8 +: 8] = 8'h00;
    step("R6 floor above");
    prioMask = '1;
    runPrio[9 +: 9] = 9'h010;
    runPrio[18 +: 9] = 9'h011;
    runPrio[27 +: 9] = 9'h000;
    step("R7 running");
    runPrio = {NC{9'd256}};
    distEnable = 0;
    step("R4 global");
    distEnable = 1; cpuEnable[4] = 0;
    step("R4 cpu");
    cpuEnable = '1;
    step("R8 settle");
    // Outputs must hold until the next edge after an input change.
    srcPending = '0;
    #1;
    compareAll("R8 latency");
    step("R8 update");
    for (int n = 0; n < 3000; n++) begin
      distEnable = ($urandom_range(0, 15) != 0);
      for (int c = 0; c < NC; c++) begin
        cpuEnable[c] = ($urandom_range(0, 7) != 0);
        prioMask[c*8 +: 8] = 8'($urandom_range(0, 255));
        runPrio[c*9 +: 9] = 9'($urandom_range(0, 256));
      end
      for (int j = 0; j < NS; j++) begin
        srcEnable[j] = ($urandom_range(0, 3) != 0);
        srcPending[j] = ($urandom_range(0, 3) == 0);
        setPrio(j, (n % 2 == 0) ? $urandom_range(0, 7) * 32 : $urandom_range(0, 255));
        for (int c = 0; c < NC; c++) srcTarget[j*NC+c] = ($urandom_range(0, 1) == 1);
      end
      step("R2 random");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R8 watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule